// File: doc/BRIEF.md
# Write-Once Non-Maskable Source Enable Register

This block holds the enables for five non-maskable interrupt sources in one 8-bit register on a simple register bus. The five sources are:

- the external non-maskable pin,
- oscillation stop detection,
- the independent watchdog underflow or refresh error,
- voltage monitor 1,
- voltage monitor 2.

Each enable bit can be set only, and only once. After it reaches 1 it stays there until reset. The block has no status flags and no edge detection. It only decides whether a raw source request reaches the combined non-maskable request output.

Each enable bit is its own two-state machine:

- **BIT_OPEN** means the bit is still 0 and can be written. Transition **ARM** leads from BIT_OPEN to BIT_LOCKED. It is taken when the bus write qualifies and the bit's data position carries 1. Every other case in BIT_OPEN is transition **IDLE**, which stays in BIT_OPEN.
- **BIT_LOCKED** means the bit is 1 and no longer writable. Every case in BIT_LOCKED is transition **HOLD**, which stays in BIT_LOCKED.

A synchronous active-low reset returns every bit to BIT_OPEN. Because the lock is kept per bit, a write may arm some sources and leave the others still open for a later write.

Top module: `nmi_src_enable`

## Requirements
- R1: After reset the register reads 00h and the request output is 0 whatever the source inputs are.
- R2: A write is one where reg_sel and reg_wr are both 1 at a rising clock edge. A 1 in a write sets the enable at that data position, and the next read shows it. The positions and sources are: bit 0 is the pin source (src_req[0]), bit 1 is oscillation stop (src_req[1]), bit 3 is the watchdog (src_req[2]), bit 4 is voltage monitor 1 (src_req[3]) and bit 5 is voltage monitor 2 (src_req[4]).
- R3: Bits 2, 6 and 7 always read 0, and writing 1 to them changes nothing.
- R4: Writing 0 to an enable bit never clears it.
- R5: Each bit locks on its own. Bits left at 0 by one write can still be set by a later write, and a set bit ignores all later writes.
- R6: When reg_sel is 0 or reg_wr is 0, no enable bit changes.
- R7: nmi_req is the OR over all five sources of src_req ANDed with that source's enable. It follows src_req in the same cycle.
- R8: Reading, with reg_sel at 1 and reg_wr at 0, changes no enable bit.
- R9: Holding rst_n low over a rising edge returns all set enable bits to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_sel | input | 1 | Register address match |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data: the enables at their positions, 0 in the reserved positions |
| src_req | input | 5 | Raw source requests: [0] pin, [1] oscillation stop, [2] watchdog, [3] voltage monitor 1, [4] voltage monitor 2 |
| nmi_req | output | 1 | Combined non-maskable request |

## Verification
- **Enables:** a write takes effect at the rising edge where it qualifies. reg_rdata shows the new enables directly after that edge, so the bench drives each vector at a falling edge and samples at the next falling edge.
- **Request output:** nmi_req has no register of its own. It is due in the same half-cycle as the new enables and the source pattern driven with them, so the bench checks it at that same falling edge.
- **Reset:** reset clears the bits at the first rising edge with rst_n low. The bench checks the cleared value one falling edge later.

// File: rtl/nmi_en_pkg.sv
package nmi_en_pkg;

    localparam int REG_W   = 8;
    localparam int NUM_SRC = 5;

    typedef enum logic {
        BIT_OPEN   = 1'b0,
        BIT_LOCKED = 1'b1
    } bit_state_e;

    // register position of each source enable
    function automatic int src_bit_pos(input int idx);
        case (idx)
            0:       return 0;
            1:       return 1;
            2:       return 3;
            3:       return 4;
            default: return 5;
        endcase
    endfunction

endpackage

// File: rtl/nmi_en_bit.sv
module nmi_en_bit
    import nmi_en_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic wr_bit,
    output logic en_o
);

    bit_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BIT_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BIT_OPEN:   if (wr_hit && wr_bit) state_d = BIT_LOCKED; // ARM
            BIT_LOCKED: state_d = BIT_LOCKED;                       // HOLD
            default:    state_d = BIT_OPEN;
        endcase
    end

    always_comb begin
        en_o = (state_q == BIT_LOCKED);
    end

    // R4 R5
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_o |=> en_o);

    // R2
    arm_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wr_bit) |=> en_o);

    // R6 R8
    no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(en_o));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> !en_o);

endmodule

// File: rtl/nmi_en_gate.sv
module nmi_en_gate #(
    parameter int N = 5
) (
    input  logic [N-1:0] src_i,
    input  logic [N-1:0] en_i,
    output logic         nmi_o
);

    logic [N-1:0] gated;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_and
            assign gated[g] = src_i[g] & en_i[g];
        end
    endgenerate

    assign nmi_o = |gated;

endmodule

// File: rtl/nmi_src_enable.sv
module nmi_src_enable
    import nmi_en_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_sel,
    input  logic               reg_wr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic [NUM_SRC-1:0] src_req,
    output logic               nmi_req
);

    logic               wr_hit;
    logic [NUM_SRC-1:0] en;

    assign wr_hit = reg_sel & reg_wr;

    genvar i;
    generate
        for (i = 0; i < NUM_SRC; i++) begin : g_bit
            nmi_en_bit u_bit (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_hit (wr_hit),
                .wr_bit (reg_wdata[src_bit_pos(i)]),
                .en_o   (en[i])
            );
        end
    endgenerate

    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            reg_rdata[src_bit_pos(k)] = en[k];
        end
    end

    nmi_en_gate #(.N(NUM_SRC)) u_gate (
        .src_i (src_req),
        .en_i  (en),
        .nmi_o (nmi_req)
    );

    // R7
    req_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> (|en));

    // R3
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[2] == 1'b0) && (reg_rdata[7:6] == 2'b00));

    // R7
    all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata == '0) |-> !nmi_req);

endmodule

// File: tb/tb_nmi_src_enable.sv
module tb_nmi_src_enable;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_sel, reg_wr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [4:0] src_req;
    logic       nmi_req;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    nmi_src_enable dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .src_req   (src_req),
        .nmi_req   (nmi_req)
    );

    typedef struct packed {
        logic       sel;
        logic       wr;
        logic [7:0] wd;
        logic [4:0] src;
        logic [7:0] exp_rd;
        logic       exp_nmi;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 8'hFF, 5'h1F, 8'h00, 1'b0, 4'd8}, // R8 read only
        '{1'b0, 1'b1, 8'hFF, 5'h1F, 8'h00, 1'b0, 4'd6}, // R6 no select
        '{1'b1, 1'b1, 8'hC4, 5'h1F, 8'h00, 1'b0, 4'd3}, // R3 reserved only
        '{1'b1, 1'b1, 8'h01, 5'h01, 8'h01, 1'b1, 4'd2}, // R2 pin
        '{1'b1, 1'b1, 8'h00, 5'h00, 8'h01, 1'b0, 4'd4}, // R4 zero write
        '{1'b1, 1'b1, 8'h02, 5'h02, 8'h03, 1'b1, 4'd2}, // R2 osc stop
        '{1'b1, 1'b1, 8'h08, 5'h04, 8'h0B, 1'b1, 4'd2}, // R2 watchdog
        '{1'b1, 1'b1, 8'h00, 5'h18, 8'h0B, 1'b0, 4'd7}, // R7 blocked
        '{1'b1, 1'b1, 8'h30, 5'h10, 8'h3B, 1'b1, 4'd5}, // R5 later set
        '{1'b1, 1'b1, 8'h00, 5'h00, 8'h3B, 1'b0, 4'd4}, // R4
        '{1'b1, 1'b0, 8'h00, 5'h08, 8'h3B, 1'b1, 4'd7}  // R7 R8
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic s, input logic w, input logic [7:0] d, input logic [4:0] r);
        @(negedge clk);
        reg_sel = s; reg_wr = w; reg_wdata = d; src_req = r;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0; src_req = 5'h1F;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 rdata", reg_rdata, 8'h00);
        check("R1 nmi", {7'd0, nmi_req}, 8'h00);

        for (int v = 0; v < NV; v++) begin
            drive(VECS[v].sel, VECS[v].wr, VECS[v].wd, VECS[v].src);
            check($sformatf("R%0d row %0d rdata", VECS[v].req, v), reg_rdata, VECS[v].exp_rd);
            check($sformatf("R%0d row %0d nmi", VECS[v].req, v), {7'd0, nmi_req}, {7'd0, VECS[v].exp_nmi});
        end

        // R5 full write of ones to a fully locked register: unchanged
        drive(1'b1, 1'b1, 8'hFF, 5'h00);
        check("R5 relock", reg_rdata, 8'h3B);

        // R7 every source alone passes when enabled
        for (int s = 0; s < 5; s++) begin
            drive(1'b0, 1'b0, 8'h00, 5'(1 << s));
            check($sformatf("R7 src %0d", s), {7'd0, nmi_req}, 8'h01);
        end

        // R9 reset clears locked bits
        @(negedge clk);
        rst_n = 1'b0; src_req = 5'h1F;
        @(negedge clk);
        check("R9 rdata", reg_rdata, 8'h00);
        check("R9 nmi", {7'd0, nmi_req}, 8'h00);
        rst_n = 1'b1;

        // R2 voltage monitor 1 alone after reset
        drive(1'b1, 1'b1, 8'h10, 5'h08);
        check("R2 vmon1 rdata", reg_rdata, 8'h10);
        check("R2 vmon1 nmi", {7'd0, nmi_req}, 8'h01);
        drive(1'b0, 1'b0, 8'h00, 5'h17);
        check("R7 other sources masked", {7'd0, nmi_req}, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule